// File: doc/BRIEF.md
# Virtual-Channel Frame Receiver

This block sits behind a 100G Ethernet MAC whose receive path has already checked and removed the FCS. Each packet it receives on a 512-bit stream has three parts. The first 64-byte beat is a header. Any number of payload beats follow, and a single footer beat closes the packet. The receiver checks the header, removes the header and footer beats, and sends the payload out on a 512-bit stream. The virtual-channel index goes out as the destination and one sideband byte goes out as the user field. The receiver also keeps the link partner's per-channel pause bitmap, a count of discarded packets and a sticky transaction-sequence error flag.

The byte count for the last payload beat and the frame-end status only arrive with the footer. For that reason, every payload beat is held for one beat before it is sent. When the footer arrives, the held beat goes out with the byte enables rebuilt from the footer. A packet whose footer has no end-of-frame mark continues the same user frame in the next packet.

The control path is a three-state machine:
- S_HDR waits for a header.
- S_BODY passes payload and expects the footer.
- S_SKIP throws away the beats of a rejected packet.

It has five transitions:
- S_HDR→S_BODY when a valid header arrives without tlast.
- S_HDR→S_SKIP when a rejected header arrives without tlast.
- S_HDR→S_HDR when a header beat carries tlast; that packet is discarded.
- S_BODY→S_HDR on the footer, which is the beat carrying tlast.
- S_SKIP→S_HDR on the beat carrying tlast.

Input byte k is `s_tdata[8k+7:8k]`.

Top module: `vcrx_receiver`

## Requirements
- R1: A header is accepted only if all three of these hold: byte 14 equals 0x01, bits [7:4] of byte 18 are zero, and the 16-bit word at bytes 30–31 (low byte first) equals the XOR of the fifteen 16-bit words at bytes 0–29. A packet with any other header produces no output beat, and `drop_count` increases by one, wrapping. A header beat that carries tlast is also discarded and counted.
- R2: Payload beats leave with their data unchanged. `m_tdest` is byte 18 bits [3:0] of the packet's header and `m_tuser` is byte 19. Every beat except the packet's final one has all 64 `m_tkeep` bits set. Beat i is presented in the cycle after payload beat i+1 or the footer is taken.
- R3: The final payload beat's `m_tkeep` has the low N bits set. N is footer byte 0, except that a value of 0 or above 64 counts as 64.
- R4: `m_tlast` on the final beat equals footer byte 1 bit 0 (end of frame) OR the error condition of R5. No other beat has `m_tlast` set.
- R5: `m_terr` is set on the final beat when any of these holds: footer byte 1 bit 1 (error end) is set, `s_tuser` is high on the footer beat (the MAC reports a bad frame), or the length check of R6 fails. `m_terr` is never set without `m_tlast`.
- R6: The length check fails when 64×(payload beats − 1) + N differs from the footer's 16-bit length at bytes 4–5 (low byte first).
- R7: `pause_map` takes header bytes 16–17 (low byte first) when a header is accepted. It takes footer bytes 2–3 at the footer of an accepted packet, unless `s_tuser` is high on that footer. At any other time it does not change.
- R8: The expected transaction ID starts at 0 and becomes (ID + 1) mod 256 after each accepted header; the ID is header byte 15. An accepted header whose ID differs from the expected value sets `seq_err`, which stays set until reset.
- R9: `m_tvalid` is high only for the beats of R2. A packet with no payload beats produces no output.
- R10: During reset `m_tvalid`, `pause_map`, `drop_count` and `seq_err` are zero, and the receiver waits for a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_tvalid | input | 1 | Input beat valid |
| s_tdata | input | 512 | Input beat data |
| s_tlast | input | 1 | Marks the footer beat of a packet |
| s_tuser | input | 1 | MAC bad-frame flag, meaningful with s_tlast |
| m_tvalid | output | 1 | Output beat valid |
| m_tdata | output | 512 | Output payload data |
| m_tkeep | output | 64 | Output byte enables |
| m_tlast | output | 1 | End of user frame |
| m_terr | output | 1 | Frame ended in error |
| m_tdest | output | 4 | Virtual-channel index |
| m_tuser | output | 8 | Sideband byte from the header |
| pause_map | output | 16 | Link partner's pause bit per channel |
| drop_count | output | 16 | Discarded packets, wrapping |
| seq_err | output | 1 | Sticky transaction-ID gap flag |

## Verification
The assertions rely on a few things about the input. The MAC never stalls, so no ready signal is assumed. Every packet ends with exactly one beat carrying tlast, and `s_tuser` is only looked at on that beat. The stimulus builds every packet as header, payload and footer, with tlast only on the closing beat. The only exception is the deliberate single-beat header packet. Gaps with `s_tvalid` low appear only between beats, and they leave the receiver's state and pause bitmap unchanged.

// File: rtl/vcrx_pkg.sv
package vcrx_pkg;

    // Byte positions inside the header beat (fixed by the wire format)
    localparam int HB_VER    = 14;
    localparam int HB_TID    = 15;
    localparam int HB_PAUSE  = 16;
    localparam int HB_VC     = 18;
    localparam int HB_SIDE   = 19;
    localparam int HB_SUM    = 30;
    localparam int HDR_BITS  = (HB_SUM + 2) * 8;
    localparam int SUM_WORDS = HB_SUM / 2;

    // Byte positions inside the footer beat
    localparam int FB_CNT    = 0;
    localparam int FB_FLAG   = 1;
    localparam int FB_PAUSE  = 2;
    localparam int FB_LEN    = 4;
    localparam int FTR_BITS  = (FB_LEN + 2) * 8;

    localparam logic [7:0] HDR_VERSION = 8'h01;
    localparam int VC_W   = 4;
    localparam int MAP_W  = 16;

    typedef enum logic [1:0] {
        S_HDR  = 2'd0,
        S_BODY = 2'd1,
        S_SKIP = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic             ok;
        logic [7:0]       tid;
        logic [MAP_W-1:0] pause;
        logic [VC_W-1:0]  vc;
        logic [7:0]       side;
    } hdr_info_t;

    typedef struct packed {
        logic [7:0]       neff;
        logic             eof;
        logic             eofe;
        logic [MAP_W-1:0] pause;
        logic [15:0]      plen;
    } ftr_info_t;

endpackage

// File: rtl/vcrx_hdr_check.sv
module vcrx_hdr_check
    import vcrx_pkg::*;
(
    input  logic [HDR_BITS-1:0] hdr,
    output hdr_info_t           info
);

    logic [15:0] sum;

    always_comb begin
        sum = '0;
        for (int i = 0; i < SUM_WORDS; i++) begin
            sum = sum ^ hdr[16*i +: 16];
        end
    end

    always_comb begin
        info.tid   = hdr[HB_TID*8 +: 8];
        info.pause = hdr[HB_PAUSE*8 +: MAP_W];
        info.vc    = hdr[HB_VC*8 +: VC_W];
        info.side  = hdr[HB_SIDE*8 +: 8];
        info.ok    = (hdr[HB_VER*8 +: 8] == HDR_VERSION)
                  && (hdr[HB_VC*8 + VC_W +: (8 - VC_W)] == '0)
                  && (sum == hdr[HB_SUM*8 +: 16]);
    end

endmodule

// File: rtl/vcrx_ftr_decode.sv
module vcrx_ftr_decode
    import vcrx_pkg::*;
#(
    parameter int KEEP_W = 64
) (
    input  logic [FTR_BITS-1:0] ftr,
    output ftr_info_t           info,
    output logic [KEEP_W-1:0]   keep
);

    logic [7:0] cnt;
    logic       rsv_unused;

    assign cnt        = ftr[FB_CNT*8 +: 8];
    assign rsv_unused = ^ftr[FB_FLAG*8 + 2 +: 6];

    always_comb begin
        info.neff  = ((cnt == 8'd0) || (cnt > 8'(KEEP_W))) ? 8'(KEEP_W) : cnt;
        info.eof   = ftr[FB_FLAG*8];
        info.eofe  = ftr[FB_FLAG*8 + 1];
        info.pause = ftr[FB_PAUSE*8 +: MAP_W];
        info.plen  = ftr[FB_LEN*8 +: 16];
    end

    for (genvar g = 0; g < KEEP_W; g++) begin : g_keep
        assign keep[g] = (8'(g) < info.neff);
    end

endmodule

// File: rtl/vcrx_seq_track.sv
module vcrx_seq_track #(
    parameter int TID_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_take,
    input  logic             hdr_drop,
    input  logic [TID_W-1:0] tid,
    output logic             seq_err,
    output logic [CNT_W-1:0] drop_count
);

    logic [TID_W-1:0] tid_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tid_next   <= '0;
            seq_err    <= 1'b0;
            drop_count <= '0;
        end else begin
            if (hdr_take) begin
                tid_next <= tid + 1'b1;
                if (tid != tid_next) seq_err <= 1'b1;
            end
            if (hdr_drop) drop_count <= drop_count + 1'b1;
        end
    end

endmodule

// File: rtl/vcrx_receiver.sv
module vcrx_receiver
    import vcrx_pkg::*;
#(
    parameter int DATA_W = 512,
    parameter int NUM_VC = 16,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s_tvalid,
    input  logic [DATA_W-1:0]   s_tdata,
    input  logic                s_tlast,
    input  logic                s_tuser,
    output logic                m_tvalid,
    output logic [DATA_W-1:0]   m_tdata,
    output logic [DATA_W/8-1:0] m_tkeep,
    output logic                m_tlast,
    output logic                m_terr,
    output logic [VC_W-1:0]     m_tdest,
    output logic [7:0]          m_tuser,
    output logic [NUM_VC-1:0]   pause_map,
    output logic [CNT_W-1:0]    drop_count,
    output logic                seq_err
);

    localparam int KEEP_W = DATA_W / 8;

    rx_state_e           state_q, state_d;
    hdr_info_t           hdr;
    ftr_info_t           ftr;
    logic [KEEP_W-1:0]   ftr_keep;
    logic                hdr_take, hdr_drop, body_beat, ftr_beat;
    logic                len_bad, end_err;
    logic [LEN_W-1:0]    byte_acc, len_rcv;
    logic                hold_valid;
    logic [DATA_W-1:0]   hold_data;
    logic [VC_W-1:0]     vc_q;
    logic [7:0]          side_q;
    logic [NUM_VC-1:0]   pause_q;

    vcrx_hdr_check u_hdr (
        .hdr  (s_tdata[HDR_BITS-1:0]),
        .info (hdr)
    );

    vcrx_ftr_decode #(.KEEP_W(KEEP_W)) u_ftr (
        .ftr  (s_tdata[FTR_BITS-1:0]),
        .info (ftr),
        .keep (ftr_keep)
    );

    vcrx_seq_track #(.TID_W(8), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hdr_take   (hdr_take),
        .hdr_drop   (hdr_drop),
        .tid        (hdr.tid),
        .seq_err    (seq_err),
        .drop_count (drop_count)
    );

    // Beat classification
    assign hdr_take  = s_tvalid && (state_q == S_HDR) && hdr.ok && !s_tlast;
    assign hdr_drop  = s_tvalid && (state_q == S_HDR) && !(hdr.ok && !s_tlast);
    assign body_beat = s_tvalid && (state_q == S_BODY) && !s_tlast;
    assign ftr_beat  = s_tvalid && (state_q == S_BODY) && s_tlast;

    // Length and end-of-chunk error
    assign len_rcv = byte_acc - LEN_W'(KEEP_W) + LEN_W'(ftr.neff);
    assign len_bad = (len_rcv != LEN_W'(ftr.plen));
    assign end_err = ftr.eofe | s_tuser | len_bad;

    assign pause_map = pause_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_HDR;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HDR: begin
                if (s_tvalid) begin
                    if (s_tlast)     state_d = S_HDR;
                    else if (hdr.ok) state_d = S_BODY;
                    else             state_d = S_SKIP;
                end
            end
            S_BODY: if (s_tvalid && s_tlast) state_d = S_HDR;
            S_SKIP: if (s_tvalid && s_tlast) state_d = S_HDR;
            default: state_d = S_HDR;
        endcase
    end

    // Outputs, holding register and per-packet context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tvalid   <= 1'b0;
            m_tdata    <= '0;
            m_tkeep    <= '0;
            m_tlast    <= 1'b0;
            m_terr     <= 1'b0;
            m_tdest    <= '0;
            m_tuser    <= '0;
            hold_valid <= 1'b0;
            hold_data  <= '0;
            byte_acc   <= '0;
            vc_q       <= '0;
            side_q     <= '0;
            pause_q    <= '0;
        end else begin
            m_tvalid <= 1'b0;
            if (hdr_take) begin
                vc_q       <= hdr.vc;
                side_q     <= hdr.side;
                pause_q    <= hdr.pause[NUM_VC-1:0];
                byte_acc   <= '0;
                hold_valid <= 1'b0;
            end
            if (body_beat) begin
                hold_data  <= s_tdata;
                hold_valid <= 1'b1;
                byte_acc   <= byte_acc + LEN_W'(KEEP_W);
                if (hold_valid) begin
                    m_tvalid <= 1'b1;
                    m_tdata  <= hold_data;
                    m_tkeep  <= '1;
                    m_tlast  <= 1'b0;
                    m_terr   <= 1'b0;
                    m_tdest  <= vc_q;
                    m_tuser  <= side_q;
                end
            end
            if (ftr_beat) begin
                hold_valid <= 1'b0;
                if (!s_tuser) pause_q <= ftr.pause[NUM_VC-1:0];
                if (hold_valid) begin
                    m_tvalid <= 1'b1;
                    m_tdata  <= hold_data;
                    m_tkeep  <= ftr_keep;
                    m_tlast  <= ftr.eof | end_err;
                    m_terr   <= end_err;
                    m_tdest  <= vc_q;
                    m_tuser  <= side_q;
                end
            end
        end
    end

endmodule

// File: rtl/vcrx_receiver_chk.sv
module vcrx_receiver_chk #(
    parameter int KEEP_W = 64,
    parameter int NUM_VC = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_tvalid,
    input logic              m_tvalid,
    input logic [KEEP_W-1:0] m_tkeep,
    input logic              m_tlast,
    input logic              m_terr,
    input logic [NUM_VC-1:0] pause_map,
    input logic [CNT_W-1:0]  drop_count,
    input logic              seq_err
);

    p_drop_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (drop_count == $past(drop_count)) || (drop_count == $past(drop_count) + 1'b1));

    p_mid_full_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tlast) |-> (&m_tkeep));

    p_keep_low_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (m_tkeep[0] && ((m_tkeep & (m_tkeep + 1'b1)) == '0)));

    p_err_ends_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_terr) |-> m_tlast);

    p_pause_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !s_tvalid |=> $stable(pause_map));

    p_seq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err);

    p_out_needs_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> $past(s_tvalid));

endmodule

bind vcrx_receiver vcrx_receiver_chk #(
    .KEEP_W (DATA_W / 8),
    .NUM_VC (NUM_VC),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_tvalid   (s_tvalid),
    .m_tvalid   (m_tvalid),
    .m_tkeep    (m_tkeep),
    .m_tlast    (m_tlast),
    .m_terr     (m_terr),
    .pause_map  (pause_map),
    .drop_count (drop_count),
    .seq_err    (seq_err)
);

// File: tb/vcrx_receiver_tb.sv
`timescale 1ns/1ps
module vcrx_receiver_tb;

    localparam int WATCHDOG = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         s_tvalid = 1'b0;
    logic [511:0] s_tdata = '0;
    logic         s_tlast = 1'b0;
    logic         s_tuser = 1'b0;
    logic         m_tvalid;
    logic [511:0] m_tdata;
    logic [63:0]  m_tkeep;
    logic         m_tlast;
    logic         m_terr;
    logic [3:0]   m_tdest;
    logic [7:0]   m_tuser;
    logic [15:0]  pause_map;
    logic [15:0]  drop_count;
    logic         seq_err;

    always #4 clk = ~clk;

    vcrx_receiver u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_tvalid(s_tvalid), .s_tdata(s_tdata), .s_tlast(s_tlast), .s_tuser(s_tuser),
        .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast),
        .m_terr(m_terr), .m_tdest(m_tdest), .m_tuser(m_tuser),
        .pause_map(pause_map), .drop_count(drop_count), .seq_err(seq_err)
    );

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    int           mst = 0;          // 0 header, 1 body, 2 skip
    logic [511:0] pq[$];
    int           npay_m = 0;
    bit           ev = 0, el = 0, ee = 0;
    logic [511:0] ed = '0;
    logic [63:0]  ek = '0;
    logic [3:0]   edst = '0, cur_dst = '0;
    logic [7:0]   eusr = '0, cur_usr = '0;
    logic [15:0]  epause = '0;
    int           edrop = 0;
    bit           eseq = 0;
    logic [7:0]   etid = '0;

    task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [511:0] rnd512();
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
        return r;
    endfunction

    function automatic logic [15:0] xsum(input logic [511:0] d);
        logic [15:0] s = '0;
        for (int i = 0; i < 15; i++) s ^= d[16*i +: 16];
        return s;
    endfunction

    function automatic bit hdr_good(input logic [511:0] d);
        return (d[119:112] == 8'h01) && (d[151:148] == 4'h0) && (d[255:240] == xsum(d));
    endfunction

    function automatic logic [63:0] keep_n(input int n);
        logic [63:0] k;
        for (int i = 0; i < 64; i++) k[i] = (i < n);
        return k;
    endfunction

    function automatic logic [511:0] mk_hdr(input logic [7:0] ver, input logic [7:0] tid,
            input logic [15:0] ph, input logic [7:0] vcb, input logic [7:0] side, input bit badsum);
        logic [511:0] h = rnd512();
        h[119:112] = ver;
        h[127:120] = tid;
        h[143:128] = ph;
        h[151:144] = vcb;
        h[159:152] = side;
        h[255:240] = xsum(h) ^ (badsum ? 16'h0100 : 16'h0000);
        return h;
    endfunction

    task automatic emit(input logic [511:0] d, input logic [63:0] k, input bit l, input bit e);
        ev = 1; ed = d; ek = k; el = l; ee = e; edst = cur_dst; eusr = cur_usr;
    endtask

    task automatic model(input bit v, input logic [511:0] d, input bit l, input bit b);
        int  neff;
        bit  lenbad, err;
        ev = 0;
        if (!v) return;
        if (mst == 0) begin
            if (hdr_good(d) && !l) begin
                if (d[127:120] != etid) eseq = 1;
                etid    = d[127:120] + 8'd1;
                epause  = d[143:128];
                cur_dst = d[147:144];
                cur_usr = d[159:152];
                pq.delete();
                npay_m  = 0;
                mst     = 1;
            end else begin
                edrop = (edrop + 1) % 65536;
                mst   = l ? 0 : 2;
            end
        end else if (mst == 1) begin
            if (!l) begin
                pq.push_back(d);
                npay_m++;
                if (pq.size() > 1) emit(pq.pop_front(), '1, 0, 0);
            end else begin
                neff   = (d[7:0] == 0 || d[7:0] > 64) ? 64 : int'(d[7:0]);
                lenbad = ((npay_m * 64 - 64 + neff) != int'(d[47:32]));
                err    = d[9] | b | lenbad;
                if (!b) epause = d[31:16];
                if (pq.size() > 0) emit(pq.pop_front(), keep_n(neff), d[8] | err, err);
                mst = 0;
            end
        end else if (l) begin
            mst = 0;
        end
    endtask

    task automatic compare();
        chk(m_tvalid === ev, "R9 valid", 512'(m_tvalid), 512'(ev));
        if (ev && m_tvalid) begin
            chk(m_tdata === ed, "R2 data", m_tdata, ed);
            chk(m_tdest === edst && m_tuser === eusr, "R2 dest/user",
                512'({m_tdest, m_tuser}), 512'({edst, eusr}));
            chk(m_tkeep === ek, "R3 keep", 512'(m_tkeep), 512'(ek));
            chk(m_tlast === el, "R4 last", 512'(m_tlast), 512'(el));
            chk(m_terr === ee, "R5/R6 err", 512'(m_terr), 512'(ee));
        end
        chk(pause_map === epause, "R7 pause", 512'(pause_map), 512'(epause));
        chk(drop_count === 16'(edrop), "R1 drops", 512'(drop_count), 512'(edrop));
        chk(seq_err === eseq, "R8 seq", 512'(seq_err), 512'(eseq));
    endtask

    task automatic step(input bit v, input logic [511:0] d, input bit l, input bit b);
        s_tvalid = v; s_tdata = d; s_tlast = l; s_tuser = b;
        model(v, d, l, b);
        @(negedge clk);
        compare();
    endtask

    // plen < 0 means the correct length
    task automatic send_pkt(input logic [7:0] ver, input logic [7:0] tid, input logic [15:0] ph,
            input logic [7:0] vcb, input logic [7:0] side, input bit badsum, input int npay,
            input logic [7:0] cnt, input logic [7:0] flags, input logic [15:0] pf,
            input int plen, input bit macbad, input bit gaps);
        logic [511:0] f;
        int neff;
        step(1, mk_hdr(ver, tid, ph, vcb, side, badsum), 0, 0);
        for (int i = 0; i < npay; i++) begin
            if (gaps) step(0, '0, 0, 0);
            step(1, rnd512(), 0, 0);
        end
        neff = (cnt == 0 || cnt > 64) ? 64 : int'(cnt);
        f = rnd512();
        f[7:0]   = cnt;
        f[15:8]  = flags;
        f[31:16] = pf;
        f[47:32] = (plen < 0) ? 16'((npay - 1) * 64 + neff) : 16'(plen);
        if (gaps) step(0, '0, 0, 0);
        step(1, f, 1, macbad);
        step(0, '0, 0, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(m_tvalid === 1'b0 && pause_map === '0 && drop_count === '0 && seq_err === 1'b0,
            "R10 reset", 512'({m_tvalid, pause_map, drop_count, seq_err}), 512'(0));
        rst_n = 1'b1;
        step(0, '0, 0, 0);

        // R2 R3 R4: plain packet, three payload beats, 20-byte last beat
        send_pkt(8'h01, 8'd0, 16'h00A5, 8'h03, 8'h5C, 0, 3, 8'd20, 8'h01, 16'h1234, -1, 0, 0);
        // R4: chunk without end-of-frame, then closing chunk with gaps and 1-byte end
        send_pkt(8'h01, 8'd1, 16'h0F00, 8'h07, 8'h11, 0, 2, 8'd64, 8'h00, 16'h0001, -1, 0, 0);
        send_pkt(8'h01, 8'd2, 16'h0002, 8'h07, 8'h22, 0, 1, 8'd1, 8'h01, 16'h8000, -1, 0, 1);
        // R1: wrong version, bad checksum, reserved VC bits, single-beat header
        send_pkt(8'h02, 8'd3, 16'hFFFF, 8'h01, 8'h33, 0, 2, 8'd8, 8'h01, 16'hFFFF, -1, 0, 0);
        send_pkt(8'h01, 8'd3, 16'hFFFF, 8'h01, 8'h33, 1, 1, 8'd8, 8'h01, 16'hFFFF, -1, 0, 0);
        send_pkt(8'h01, 8'd3, 16'hFFFF, 8'h15, 8'h33, 0, 1, 8'd8, 8'h01, 16'hFFFF, -1, 0, 0);
        step(1, mk_hdr(8'h01, 8'd3, 16'hFFFF, 8'h01, 8'h33, 0), 1, 0);
        step(0, '0, 0, 0);
        // R5 R7: MAC bad-frame flag, footer pause ignored
        send_pkt(8'h01, 8'd3, 16'h0A0A, 8'h0E, 8'h44, 0, 2, 8'd33, 8'h01, 16'h5555, -1, 1, 0);
        // R6: length field mismatch
        send_pkt(8'h01, 8'd4, 16'h0101, 8'h02, 8'h55, 0, 2, 8'd10, 8'h01, 16'h0202, 100, 0, 0);
        // R5 R3: error-end flag with count 0 taken as 64
        send_pkt(8'h01, 8'd5, 16'h0303, 8'h0F, 8'h66, 0, 1, 8'd0, 8'h03, 16'h0404, -1, 0, 0);
        // R3: count above 64 taken as 64
        send_pkt(8'h01, 8'd6, 16'h0505, 8'h00, 8'h77, 0, 2, 8'd200, 8'h01, 16'h0606, -1, 0, 1);
        // R9: no payload beats, footer still refreshes pause (R7)
        send_pkt(8'h01, 8'd7, 16'h0707, 8'h04, 8'h88, 0, 0, 8'd5, 8'h01, 16'hBEEF, 0, 0, 0);
        // R8: transaction-ID gap, then stays sticky
        send_pkt(8'h01, 8'd9, 16'h0909, 8'h05, 8'h99, 0, 1, 8'd12, 8'h01, 16'h0A0A, -1, 0, 0);
        send_pkt(8'h01, 8'd10, 16'h0B0B, 8'h06, 8'hAA, 0, 2, 8'd64, 8'h01, 16'h0C0C, -1, 0, 0);
        repeat (3) step(0, '0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule